// File: doc/BRIEF.md
# Serial Configuration EEPROM Boot Reader

This block masters a three-wire serial configuration EEPROM and reads 16-bit words from it. It drives the select, shift clock and serial data-in pins and samples the serial data-out pin. Every access begins with a short select-low phase. The block then shifts out a read command and address and clocks in a 16-bit word, most significant bit first. Each clock phase lasts a programmable number of system clocks, which keeps the serial clock within the memory's limit.

When reset is released, a sequencer reads the first sixteen words of the memory in ascending order. The words are treated as little-endian, so the low byte of each word sits at the even byte address. The sequencer keeps bytes 20 to 25 and presents them as a 48-bit station address with a valid flag. After this sweep the host can read any of the 64 words through a strobe, address, word and done interface.

Top module: `eep_cfg_boot`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `eep_cs_o`, `eep_sk_o`, `eep_di_o`, `rd_done_o` and `mac_valid_o` are low.
- R2: Once reset is released, the block reads words 0 to 15 in ascending order without any request. `busy_o` stays high during this sweep. A host strobe given before `mac_valid_o` rises starts no access and gives no `rd_done_o`.
- R3: Each access shifts out 11 bits on `eep_di_o`, most significant first: two zeros, the read pattern 1,1,0, then the 6 address bits from bit 5 down to bit 0. Each bit is set while `eep_sk_o` is low and held across its rising edge.
- R4: When an access is accepted, `eep_cs_o` stays low for one phase. It then rises HALF_CYC+1 cycles after the strobe is driven and stays high until the access ends. It is low whenever the block is idle.
- R5: After the 11th rising edge of the shift clock, 16 more rising edges follow. Data bit 15-k is sampled from `eep_do_i` while the clock is high after rising edge 12+k. The result is returned in `rd_word_o`.
- R6: Every clock phase lasts HALF_CYC system clocks. Consecutive rising edges of `eep_sk_o` within one access are 2*HALF_CYC cycles apart.
- R7: When an access finishes, `rd_done_o` is high for exactly one cycle. In that same cycle `rd_word_o` holds the word, and `busy_o` and `eep_cs_o` are low.
- R8: A strobe given while `busy_o` is high is ignored. The running access completes with its own address, and no extra access follows.
- R9: After the sweep, `mac_valid_o` goes high and stays high. `mac_o[47:40]` is byte 20 and `mac_o[7:0]` is byte 25. Byte 2w is the low byte of word w and byte 2w+1 is its high byte.
- R10: After the sweep, the host can read any word address from 0 to 63, including both ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_start_i | input | 1 | Host read strobe |
| rd_addr_i | input | 6 | Host word address |
| rd_word_o | output | 16 | Last word read |
| rd_done_o | output | 1 | One-cycle pulse when a host read completes |
| busy_o | output | 1 | Sweep or access in progress |
| mac_o | output | 48 | Station address, bytes 20 to 25 |
| mac_valid_o | output | 1 | Station address valid |
| eep_cs_o | output | 1 | Memory select |
| eep_sk_o | output | 1 | Memory shift clock |
| eep_di_o | output | 1 | Serial data to the memory |
| eep_do_i | input | 1 | Serial data from the memory |

## Verification
The bench contains a memory model that decodes each command from the pins and serves words filled from a fixed seed. The targets are:
- **Byte order:** a design that swapped the bytes inside a word would give a scrambled station address.
- **Early host strobes:** a strobe given during the sweep would appear as an extra entry in the command log or as an early done.
- **Strobes during an access:** a design that restarted on such a strobe would return the wrong word or add an access.
- **Address extremes and data edges:** reads at addresses 0 and 63 and all-ones data catch off-by-one errors in the shift counts, which would drop or duplicate an edge bit.
- **Timing:** the timing of the select-low phase and the spacing of clock edges are measured in system cycles.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned CMD_W  = 11;
  localparam logic [2:0]  RD_OP  = 3'b110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CSLO, ST_CMD_LO, ST_CMD_HI, ST_DAT_LO, ST_DAT_HI, ST_TAIL
  } eep_state_e;
endpackage

// File: rtl/eep_rd_engine.sv
module eep_rd_engine
  import eep_pkg::*;
#(
  parameter int unsigned HALF_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  input  logic              do_i
);
  localparam int unsigned TMR_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [TMR_W-1:0] TMR_LD = TMR_W'(HALF_CYC - 1);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(WORD_W - 1);

  eep_state_e        state_q;
  logic [TMR_W-1:0]  tmr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [WORD_W-1:0] dat_q, word_q;
  logic              cs_q, sk_q, di_q, done_q;
  logic              phase_end;

  assign phase_end = (tmr_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      cnt_q   <= '0;
      cmd_q   <= '0;
      dat_q   <= '0;
      word_q  <= '0;
      cs_q    <= 1'b0;
      sk_q    <= 1'b0;
      di_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (start_i) begin
          cmd_q   <= {2'b00, RD_OP, addr_i};
          cnt_q   <= '0;
          tmr_q   <= TMR_LD;
          state_q <= ST_CSLO;
        end
      end else begin
        tmr_q <= phase_end ? TMR_LD : tmr_q - 1'b1;
        if (phase_end) begin
          unique case (state_q)
            ST_CSLO: begin
              cs_q    <= 1'b1;
              di_q    <= cmd_q[CMD_W-1];
              state_q <= ST_CMD_LO;
            end
            ST_CMD_LO: begin
              sk_q    <= 1'b1;
              state_q <= ST_CMD_HI;
            end
            ST_CMD_HI: begin
              sk_q <= 1'b0;
              if (cnt_q == CMD_LAST) begin
                cnt_q   <= '0;
                di_q    <= 1'b0;
                state_q <= ST_DAT_LO;
              end else begin
                cnt_q   <= cnt_q + 1'b1;
                cmd_q   <= cmd_q << 1;
                di_q    <= cmd_q[CMD_W-2];
                state_q <= ST_CMD_LO;
              end
            end
            ST_DAT_LO: begin
              sk_q    <= 1'b1;
              state_q <= ST_DAT_HI;
            end
            ST_DAT_HI: begin
              sk_q  <= 1'b0;
              dat_q <= {dat_q[WORD_W-2:0], do_i};
              if (cnt_q == DAT_LAST) begin
                state_q <= ST_TAIL;
              end else begin
                cnt_q   <= cnt_q + 1'b1;
                state_q <= ST_DAT_LO;
              end
            end
            ST_TAIL: begin
              cs_q    <= 1'b0;
              word_q  <= dat_q;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign word_o = word_q;
  assign cs_o   = cs_q;
  assign sk_o   = sk_q;
  assign di_o   = di_q;

  AST_SK_WITHIN_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sk_o |-> cs_o); // R4
  AST_DI_HELD_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sk_o) |-> $stable(di_o)); // R3
  AST_CS_RISE_AFTER_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> $past(busy_o) && $past(state_q) == ST_CSLO); // R4
  AST_DONE_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !cs_o && !sk_o); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_BUSY_IGNORES_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o && start_i && state_q != ST_TAIL |=> busy_o); // R8
  AST_NO_PHASE_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !phase_end |=> $stable(sk_o) && $stable(cs_o)); // R6
endmodule

// File: rtl/eep_boot_seq.sv
module eep_boot_seq
  import eep_pkg::*;
#(
  parameter int unsigned BOOT_WORDS = 16,
  parameter int unsigned MAC_BYTE   = 20,
  parameter int unsigned MAC_BYTES  = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   eng_busy_i,
  input  logic                   eng_done_i,
  input  logic [WORD_W-1:0]      eng_word_i,
  output logic                   seq_act_o,
  output logic                   seq_start_o,
  output logic [ADDR_W-1:0]      seq_addr_o,
  output logic [8*MAC_BYTES-1:0] mac_o,
  output logic                   mac_valid_o
);
  localparam int unsigned IDX_W    = $clog2(BOOT_WORDS + 1);
  localparam int unsigned MAC_W0   = MAC_BYTE / 2;
  localparam int unsigned MAC_WN   = (MAC_BYTES + 1) / 2;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BOOT_WORDS - 1);

  logic             act_q, wait_q, valid_q;
  logic [IDX_W-1:0] idx_q;
  logic [WORD_W-1:0] mw_q [MAC_WN];

  assign seq_start_o = act_q && !wait_q && !eng_busy_i;
  assign seq_addr_o  = ADDR_W'(idx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b1;
      wait_q  <= 1'b0;
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else if (act_q) begin
      if (seq_start_o) wait_q <= 1'b1;
      if (eng_done_i && wait_q) begin
        wait_q <= 1'b0;
        idx_q  <= idx_q + 1'b1;
        if (idx_q == IDX_LAST) begin
          act_q   <= 1'b0;
          valid_q <= 1'b1;
        end
      end
    end
  end

  for (genvar w = 0; w < MAC_WN; w++) begin : g_mw
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mw_q[w] <= '0;
      else if (act_q && wait_q && eng_done_i && idx_q == IDX_W'(MAC_W0 + w))
        mw_q[w] <= eng_word_i;
    end
  end

  // byte MAC_BYTE lands in the top byte of mac_o; low byte of a word is the even byte
  for (genvar b = 0; b < MAC_BYTES; b++) begin : g_mb
    localparam int unsigned ABS = MAC_BYTE + b;
    localparam int unsigned WI  = ABS / 2 - MAC_W0;
    localparam int unsigned HI  = ABS % 2;
    assign mac_o[8*(MAC_BYTES-b)-1 -: 8] = mw_q[WI][8*HI +: 8];
  end

  assign seq_act_o   = act_q;
  assign mac_valid_o = valid_q;

  AST_VALID_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_valid_o |=> mac_valid_o && $stable(mac_o)); // R9
  AST_SWEEP_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_start_o && idx_q != '0 |-> $past(idx_q) == idx_q - 1'b1 || $past(idx_q) == idx_q); // R2
  AST_ACT_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(act_q && valid_q)); // R2
endmodule

// File: rtl/eep_cfg_boot.sv
module eep_cfg_boot
  import eep_pkg::*;
#(
  parameter int unsigned HALF_CYC   = 4,
  parameter int unsigned BOOT_WORDS = 16,
  parameter int unsigned MAC_BYTE   = 20
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rd_start_i,
  input  logic [5:0]  rd_addr_i,
  output logic [15:0] rd_word_o,
  output logic        rd_done_o,
  output logic        busy_o,
  output logic [47:0] mac_o,
  output logic        mac_valid_o,
  output logic        eep_cs_o,
  output logic        eep_sk_o,
  output logic        eep_di_o,
  input  logic        eep_do_i
);
  logic              eng_start, eng_busy, eng_done;
  logic [ADDR_W-1:0] eng_addr, seq_addr;
  logic [WORD_W-1:0] eng_word;
  logic              seq_act, seq_start;

  eep_boot_seq #(
    .BOOT_WORDS(BOOT_WORDS),
    .MAC_BYTE  (MAC_BYTE),
    .MAC_BYTES (6)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .eng_busy_i (eng_busy),
    .eng_done_i (eng_done),
    .eng_word_i (eng_word),
    .seq_act_o  (seq_act),
    .seq_start_o(seq_start),
    .seq_addr_o (seq_addr),
    .mac_o      (mac_o),
    .mac_valid_o(mac_valid_o)
  );

  assign eng_start = seq_act ? seq_start : rd_start_i;
  assign eng_addr  = seq_act ? seq_addr  : rd_addr_i;

  eep_rd_engine #(.HALF_CYC(HALF_CYC)) u_eng (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(eng_start),
    .addr_i (eng_addr),
    .busy_o (eng_busy),
    .done_o (eng_done),
    .word_o (eng_word),
    .cs_o   (eep_cs_o),
    .sk_o   (eep_sk_o),
    .di_o   (eep_di_o),
    .do_i   (eep_do_i)
  );

  assign rd_word_o = eng_word;
  assign rd_done_o = eng_done && !seq_act;
  assign busy_o    = eng_busy || seq_act;

  AST_NO_HOST_DONE_IN_BOOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mac_valid_o |-> !rd_done_o); // R2
  AST_BUSY_DURING_SWEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mac_valid_o |-> busy_o); // R2
endmodule

// File: tb/eep_cfg_boot_tb.sv
module eep_cfg_boot_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_start = 1'b0;
  logic [5:0]  rd_addr = '0;
  logic [15:0] rd_word;
  logic        rd_done, busy, mac_valid;
  logic [47:0] mac;
  logic        cs, sk, di;
  logic        do_bit = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  logic [15:0] mem [64];
  logic [10:0] cmd_log [256];
  int          n_acc = 0;
  int          edge_cnt = 0, cyc = 0, last_rise = -1, bad_period = 0;
  logic [10:0] cmd_sr = '0;
  logic        prev_sk = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eep_cfg_boot #(.HALF_CYC(HALF)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_start_i(rd_start), .rd_addr_i(rd_addr),
    .rd_word_o(rd_word), .rd_done_o(rd_done), .busy_o(busy), .mac_o(mac),
    .mac_valid_o(mac_valid), .eep_cs_o(cs), .eep_sk_o(sk), .eep_di_o(di),
    .eep_do_i(do_bit)
  );

  // memory model, decodes the pins at negedges
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!cs) begin
      edge_cnt  = 0;
      last_rise = -1;
    end else if (sk && !prev_sk) begin
      edge_cnt = edge_cnt + 1;
      if (last_rise >= 0 && cyc - last_rise != 2*HALF) bad_period = bad_period + 1;
      last_rise = cyc;
      if (edge_cnt <= 11) begin
        cmd_sr = {cmd_sr[9:0], di};
        if (edge_cnt == 11) begin
          cmd_log[n_acc[7:0]] = cmd_sr;
          n_acc = n_acc + 1;
        end
      end else if (edge_cnt <= 27) begin
        do_bit = mem[cmd_sr[5:0]][27 - edge_cnt];
      end
    end
    prev_sk = sk;
  end

  function automatic logic [10:0] exp_cmd(input logic [5:0] a);
    return {2'b00, 3'b110, a};
  endfunction

  function automatic logic [47:0] exp_mac();
    logic [7:0] bytes [32];
    for (int w = 0; w < 16; w++) begin
      bytes[2*w]   = mem[w][7:0];
      bytes[2*w+1] = mem[w][15:8];
    end
    return {bytes[20], bytes[21], bytes[22], bytes[23], bytes[24], bytes[25]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_read(input logic [5:0] a, input bit poke, input logic [5:0] pa);
    int k, acc0;
    acc0 = n_acc;
    @(negedge clk);
    rd_addr  = a;
    rd_start = 1'b1;
    k = 0;
    do begin
      @(negedge clk);
      rd_start = 1'b0;
      k++;
      if (k == 1) check(busy && !cs, "R4 busy and select low after strobe", {busy, cs}, 2'b10);
    end while (!cs && k < 50);
    check(k == HALF + 1, "R4 select rise delay", k, HALF + 1);
    if (poke) begin
      repeat (10) @(negedge clk);
      rd_addr  = pa;
      rd_start = 1'b1;
      @(negedge clk);
      rd_start = 1'b0;
    end
    k = 0;
    while (!rd_done && k < 2000) begin
      @(negedge clk);
      k++;
    end
    check(rd_done, "R7 done seen", rd_done, 1);
    check(rd_word == mem[a], "R5 word value", rd_word, mem[a]);
    check(!busy && !cs, "R7 idle at done", {busy, cs}, 0);
    check(n_acc == acc0 + 1, "R8 single access", n_acc, acc0 + 1);
    check(cmd_log[acc0[7:0]] == exp_cmd(a), "R3 command bits", cmd_log[acc0[7:0]], exp_cmd(a));
    @(negedge clk);
    check(!rd_done, "R7 done one cycle", rd_done, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) mem[i] = 16'($urandom);
    mem[0]  = 16'h8001;
    mem[63] = 16'hFFFF;
    mem[10] = 16'h2211;
    repeat (3) @(negedge clk);
    check(!cs && !sk && !di && !rd_done && !mac_valid, "R1 reset outputs",
          {cs, sk, di, rd_done, mac_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!cs && !sk && !di && !rd_done && !mac_valid, "R1 after release",
          {cs, sk, di, rd_done, mac_valid}, 0);
    check(busy, "R2 busy during sweep", busy, 1);
    begin
      int k, early;
      k = 0; early = 0;
      while (!mac_valid && k < 20000) begin
        if (k == 300 || k == 1200) begin rd_addr = 6'd40; rd_start = 1'b1; end
        else rd_start = 1'b0;
        if (rd_done) early++;
        @(negedge clk);
        k++;
      end
      rd_start = 1'b0;
      check(early == 0, "R2 no host done in sweep", early, 0);
    end
    check(mac_valid, "R9 valid after sweep", mac_valid, 1);
    check(n_acc == 16, "R2 sweep access count", n_acc, 16);
    for (int i = 0; i < 16; i++)
      check(cmd_log[i] == exp_cmd(6'(i)), "R2 R3 sweep order", cmd_log[i], exp_cmd(6'(i)));
    check(mac == exp_mac(), "R9 station address", mac, exp_mac());
    check(mac[47:40] == 8'h11, "R9 byte 20 low byte of word 10", mac[47:40], 8'h11);
    repeat (5) @(negedge clk);
    check(!busy && !cs, "R4 idle select low", {busy, cs}, 0);

    host_read(6'd0, 1'b0, 6'd0);    // R10 bottom address
    host_read(6'd63, 1'b0, 6'd0);   // R10 top address, all-ones data
    host_read(6'd21, 1'b1, 6'd5);   // R8 strobe during access
    for (int i = 0; i < 20; i++) host_read(6'($urandom % 64), 1'b0, 6'd0);
    check(mac_valid && mac == exp_mac(), "R9 address sticky", mac, exp_mac());
    check(bad_period == 0, "R6 clock edge spacing", bad_period, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule